// File: doc/BRIEF.md
# Parallel Configuration Port Master

This block brings up a downstream programmable logic device over its byte-wide slave configuration port. A load request starts a fixed-length reset pulse on the device's program pin. The block then waits until the device reports that it is ready. It then holds chip select and write asserted and clocks one byte per configuration-clock period from an incoming valid/ready byte stream. If the device reports it is busy, the block optionally stalls with extra clock pulses. After the final byte it keeps clocking until the device signals completion. Every wait carries a timeout; when a timeout expires the operation fails and a one-cycle abort strobe is raised for external cleanup.

A readback request reads a requested number of bytes from the device. It asserts chip select with write held inactive, gives each byte a clock pulse and then samples the bus. The sampled bytes leave on an output strobe. Readback ends with chip select released and one trailing clock pulse. The configuration clock half-period, the program pulse length and the timeout length are all parameters counted in system clocks.

Top module: `cfg_loader_par`

## Requirements
- R1: After reset, `prog_n`, `cs_n`, `wr_n` and `cclk` are high, `cfg_d_oe`, `s_ready`, `m_valid`, `op_busy` and `abort_pulse` are low.
- R2: A load drives `prog_n` low for exactly PROG_CYCLES system clocks and then high, with `cs_n` high and the bus undriven meanwhile.
- R3: After `prog_n` returns high, `cs_n` stays high until `init_n` is high and `dev_busy` is low. If that does not happen within TIMEOUT_CYCLES clocks, the load fails with `stat_timeout` set and `abort_pulse` raised.
- R4: `cs_n` and `wr_n` go low together, with `cclk` high, before the first byte and stay low for every byte. `cfg_d_oe` is high only while both are low.
- R5: Each accepted byte is placed on `cfg_d_o`. It stays unchanged while `cclk` is driven low for HALF_DIV clocks and then high. Bytes reach the device in stream order, and `s_last` high marks the final byte.
- R6: With `busy_chk_en` high and `dev_busy` seen high after a byte's rising edge, `cclk` keeps pulsing with the same data until `dev_busy` is low. With `busy_chk_en` low, exactly one rising edge is issued per byte.
- R7: A busy stall lasting beyond TIMEOUT_CYCLES fails the load, releases `cs_n` and `wr_n`, and raises `abort_pulse`.
- R8: After the final byte, `cs_n` rises first and `wr_n` rises one or more clocks later.
- R9: After release, `cclk` pulses until `done_in` is high; no pulse is issued if it is already high. On success `stat_ok` is set and `stat_timeout` is clear.
- R10: If `done_in` stays low beyond TIMEOUT_CYCLES, `abort_pulse` is high for exactly one clock, `stat_timeout` is set and `stat_ok` is clear.
- R11: A readback of `rd_len` bytes asserts `cs_n` with `wr_n` high and the bus undriven. For each byte it gives one `cclk` pulse, then samples `cfg_d_i` and presents it on `m_data` with a one-clock `m_valid`, in order.
- R12: Readback ends by releasing `cs_n` and issuing exactly one more `cclk` pulse, then sets `stat_ok`. A length of zero yields only that one pulse.
- R13: `start_load` and `start_rdbk` are ignored while `op_busy` is high. When both are high in the idle state, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_load | input | 1 | Begin a configuration load |
| start_rdbk | input | 1 | Begin a readback |
| busy_chk_en | input | 1 | Stall on device busy during load |
| rd_len | input | LEN_W | Readback byte count, sampled at start |
| s_data | input | 8 | Load stream byte |
| s_valid | input | 1 | Load stream byte valid |
| s_last | input | 1 | Load stream final byte |
| s_ready | output | 1 | Load stream byte taken |
| m_data | output | 8 | Readback byte |
| m_valid | output | 1 | Readback byte strobe |
| prog_n | output | 1 | Device program, active low |
| cs_n | output | 1 | Device chip select, active low |
| wr_n | output | 1 | Device write, active low |
| cclk | output | 1 | Configuration clock |
| cfg_d_o | output | 8 | Bus drive value |
| cfg_d_oe | output | 1 | Bus output enable |
| cfg_d_i | input | 8 | Bus sampled value |
| init_n | input | 1 | Device init status, high when ready |
| dev_busy | input | 1 | Device busy, active high |
| done_in | input | 1 | Device configuration complete |
| op_busy | output | 1 | Operation in progress |
| stat_ok | output | 1 | Last operation succeeded |
| stat_timeout | output | 1 | Last operation timed out |
| abort_pulse | output | 1 | One-clock strobe on timeout |

## Verification
The checker watches several properties on every cycle. It checks that the program pulse never overlaps chip select or bus drive, and that the bus is driven only under asserted select and write. It checks that bus data holds across each rising configuration-clock edge and that every low phase lasts exactly the divider count. It also checks that write is released only after select, that readback strobes appear only with select low and write high, and that the abort strobe is a single cycle that coincides with the timeout status. Several properties depend on a device model reacting to the pins over many cycles, so only the bench scenarios can show them. These are byte ordering, the number of extra pulses for a busy stall or a late completion signal, the timeout paths and the trailing readback pulse.

// File: rtl/cfg_loader_par.sv
module cfg_loader_par #(
  parameter int PROG_CYCLES    = 40,
  parameter int HALF_DIV       = 4,
  parameter int TIMEOUT_CYCLES = 2_000_000,
  parameter int LEN_W          = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_load,
  input  logic             start_rdbk,
  input  logic             busy_chk_en,
  input  logic [LEN_W-1:0] rd_len,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  output logic [7:0]       m_data,
  output logic             m_valid,
  output logic             prog_n,
  output logic             cs_n,
  output logic             wr_n,
  output logic             cclk,
  output logic [7:0]       cfg_d_o,
  output logic             cfg_d_oe,
  input  logic [7:0]       cfg_d_i,
  input  logic             init_n,
  input  logic             dev_busy,
  input  logic             done_in,
  output logic             op_busy,
  output logic             stat_ok,
  output logic             stat_timeout,
  output logic             abort_pulse
);
  localparam int CW = $clog2(PROG_CYCLES + HALF_DIV + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);
  localparam logic [TW-1:0] TO_LIMIT  = TW'(TIMEOUT_CYCLES);

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WRDY, S_FETCH, S_LDCHK, S_RELCS, S_RELWR,
    S_DONE, S_FAIL, S_RBCHK, S_RBSAMP, S_RBEND, S_RBFIN, S_CLO, S_CHI
  } st_t;

  st_t              st, ret;
  logic [CW-1:0]    cnt;
  logic [TW-1:0]    tmr;
  logic [LEN_W-1:0] rem;
  logic             last_q, fail_q;

  assign s_ready = (st == S_FETCH);
  assign op_busy = (st != S_IDLE);

  wire to_hit  = (tmr == TO_LIMIT);
  wire tmr_clr = (st == S_PROG) || (st == S_FETCH && s_valid) || (st == S_RELWR);
  wire dev_rdy = init_n && !dev_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmr <= '0;
    else if (tmr_clr)  tmr <= '0;
    else if (!to_hit)  tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE; cnt <= '0; rem <= '0;
      last_q <= 1'b0; fail_q <= 1'b0;
      prog_n <= 1'b1; cs_n <= 1'b1; wr_n <= 1'b1; cclk <= 1'b1;
      cfg_d_o <= '0; cfg_d_oe <= 1'b0;
      m_data <= '0; m_valid <= 1'b0;
      stat_ok <= 1'b0; stat_timeout <= 1'b0; abort_pulse <= 1'b0;
    end else begin
      m_valid     <= 1'b0;
      abort_pulse <= 1'b0;
      unique case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start_load) begin
            stat_ok <= 1'b0; stat_timeout <= 1'b0; fail_q <= 1'b0;
            prog_n <= 1'b0;
            st <= S_PROG;
          end else if (start_rdbk) begin
            stat_ok <= 1'b0; stat_timeout <= 1'b0;
            cs_n <= 1'b0;
            rem <= rd_len;
            st <= S_RBCHK;
          end
        end
        S_PROG: begin
          if (cnt == PROG_LAST) begin
            prog_n <= 1'b1; cnt <= '0; st <= S_WRDY;
          end else cnt <= cnt + 1'b1;
        end
        S_WRDY: begin
          if (dev_rdy) begin
            wr_n <= 1'b0; cs_n <= 1'b0; cclk <= 1'b1; cfg_d_oe <= 1'b1;
            st <= S_FETCH;
          end else if (to_hit) st <= S_FAIL;
        end
        S_FETCH: begin
          if (s_valid) begin
            cfg_d_o <= s_data; last_q <= s_last;
            ret <= S_LDCHK; st <= S_CLO;
          end
        end
        S_LDCHK: begin
          if (busy_chk_en && dev_busy) begin
            if (to_hit) begin
              fail_q <= 1'b1; st <= S_RELCS;
            end else begin
              ret <= S_LDCHK; st <= S_CLO;
            end
          end else if (last_q) st <= S_RELCS;
          else st <= S_FETCH;
        end
        S_RELCS: begin
          cs_n <= 1'b1; cfg_d_oe <= 1'b0; st <= S_RELWR;
        end
        S_RELWR: begin
          wr_n <= 1'b1;
          st <= fail_q ? S_FAIL : S_DONE;
        end
        S_DONE: begin
          if (done_in) begin
            stat_ok <= 1'b1; st <= S_IDLE;
          end else if (to_hit) st <= S_FAIL;
          else begin
            ret <= S_DONE; st <= S_CLO;
          end
        end
        S_FAIL: begin
          abort_pulse <= 1'b1; stat_timeout <= 1'b1;
          cs_n <= 1'b1; wr_n <= 1'b1; cfg_d_oe <= 1'b0;
          st <= S_IDLE;
        end
        S_RBCHK: begin
          if (rem == '0) st <= S_RBEND;
          else begin
            ret <= S_RBSAMP; st <= S_CLO;
          end
        end
        S_RBSAMP: begin
          m_data <= cfg_d_i; m_valid <= 1'b1;
          rem <= rem - 1'b1;
          st <= S_RBCHK;
        end
        S_RBEND: begin
          cs_n <= 1'b1; ret <= S_RBFIN; st <= S_CLO;
        end
        S_RBFIN: begin
          stat_ok <= 1'b1; st <= S_IDLE;
        end
        S_CLO: begin
          if (cnt == HALF_LAST) begin
            cclk <= 1'b0; cnt <= '0; st <= S_CHI;
          end else cnt <= cnt + 1'b1;
        end
        S_CHI: begin
          if (cnt == HALF_LAST) begin
            cclk <= 1'b1; cnt <= '0; st <= ret;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader_par_chk.sv
module cfg_loader_par_chk #(
  parameter int HALF_DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_n,
  input logic       cs_n,
  input logic       wr_n,
  input logic       cclk,
  input logic [7:0] cfg_d_o,
  input logic       cfg_d_oe,
  input logic       m_valid,
  input logic       abort_pulse,
  input logic       stat_ok,
  input logic       stat_timeout
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_cnt <= '0;
    else if (cclk) low_cnt <= '0;
    else           low_cnt <= low_cnt + 1'b1;
  end

  assert_prog_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (cs_n && !cfg_d_oe));

  assert_drive_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_d_oe |-> (!cs_n && !wr_n));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cclk) && cfg_d_oe) |-> $stable(cfg_d_o));

  assert_low_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> (low_cnt == 16'(HALF_DIV)));

  assert_release_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> $past(cs_n));

  assert_status_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_ok && stat_timeout));

  assert_abort_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  assert_abort_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> stat_timeout);

  assert_rdbk_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (!cs_n && wr_n && !cfg_d_oe));
endmodule

bind cfg_loader_par cfg_loader_par_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .cs_n(cs_n), .wr_n(wr_n),
  .cclk(cclk), .cfg_d_o(cfg_d_o), .cfg_d_oe(cfg_d_oe), .m_valid(m_valid),
  .abort_pulse(abort_pulse), .stat_ok(stat_ok), .stat_timeout(stat_timeout)
);

// File: tb/cfg_loader_par_bench.sv
`timescale 1ns/1ps
module cfg_loader_par_bench;
  localparam int PROG = 4;
  localparam int HALF = 2;
  localparam int TO   = 300;
  localparam int LW   = 8;

  logic clk = 0, rst_n = 0;
  logic start_load = 0, start_rdbk = 0, busy_chk_en = 0;
  logic [LW-1:0] rd_len = '0;
  logic [7:0] s_data = '0;
  logic s_valid = 0, s_last = 0, s_ready;
  logic [7:0] m_data;
  logic m_valid, prog_n, cs_n, wr_n, cclk, cfg_d_oe;
  logic [7:0] cfg_d_o;
  logic [7:0] cfg_d_i = '0;
  logic init_n = 1, dev_busy = 0, done_in = 0;
  logic op_busy, stat_ok, stat_timeout, abort_pulse;

  always #2.5 clk = ~clk;

  cfg_loader_par #(.PROG_CYCLES(PROG), .HALF_DIV(HALF), .TIMEOUT_CYCLES(TO), .LEN_W(LW)) u_cfg_loader_par (
    .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_rdbk(start_rdbk),
    .busy_chk_en(busy_chk_en), .rd_len(rd_len), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .m_data(m_data), .m_valid(m_valid),
    .prog_n(prog_n), .cs_n(cs_n), .wr_n(wr_n), .cclk(cclk), .cfg_d_o(cfg_d_o),
    .cfg_d_oe(cfg_d_oe), .cfg_d_i(cfg_d_i), .init_n(init_n), .dev_busy(dev_busy),
    .done_in(done_in), .op_busy(op_busy), .stat_ok(stat_ok),
    .stat_timeout(stat_timeout), .abort_pulse(abort_pulse)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] src [0:63];
  logic [7:0] cap [0:63];
  logic [7:0] mv  [0:63];
  int cap_n, mv_n, rises_ld, rises_rb, rises_post, stall_at, stall_left;
  int done_after, init_delay, rb_k, prog_cnt, abort_cnt, oe_bad, wait_cyc;
  bit init_stuck, cs_fell, init_up;
  time t_cs_rise, t_wr_rise, t_cs_fall, t_init;

  function automatic logic [7:0] pat(input int k);
    return 8'hA5 ^ 8'(k * 37);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge cclk) begin
    if (!cs_n && !wr_n) begin
      rises_ld++;
      if (dev_busy) begin
        if (stall_left > 0) stall_left--;
        if (stall_left == 0) begin #1 dev_busy = 0; end
      end else begin
        if (cap_n < 64) cap[cap_n] = cfg_d_o;
        cap_n++;
        if (cap_n == stall_at && stall_left > 0) begin #1 dev_busy = 1; end
      end
    end else if (!cs_n && wr_n) begin
      rises_rb++;
      #1 cfg_d_i = pat(rb_k);
      rb_k++;
    end else if (op_busy) begin
      rises_post++;
      if (rises_post == done_after) begin #1 done_in = 1; end
    end
  end

  always @(negedge prog_n) init_n = 0;
  always @(posedge prog_n) if (rst_n && !init_stuck) begin
    repeat (init_delay) @(posedge clk);
    #1 init_n = 1; t_init = $time; init_up = 1;
  end
  always @(posedge cs_n) t_cs_rise = $time;
  always @(posedge wr_n) t_wr_rise = $time;
  always @(negedge cs_n) begin t_cs_fall = $time; cs_fell = 1; end

  always @(negedge clk) begin
    if (!prog_n) prog_cnt++;
    if (abort_pulse) abort_cnt++;
    if (cfg_d_oe && (cs_n || wr_n)) oe_bad++;
    if (m_valid) begin
      if (mv_n < 64) mv[mv_n] = m_data;
      mv_n++;
    end
    if (op_busy && prog_n && !cs_fell) wait_cyc++;
  end

  task automatic prep(input int dly, input int st_at, input int st_len, input int d_after);
    cap_n = 0; mv_n = 0; rises_ld = 0; rises_rb = 0; rises_post = 0; rb_k = 0;
    prog_cnt = 0; abort_cnt = 0; oe_bad = 0; wait_cyc = 0;
    cs_fell = 0; init_up = 0; init_stuck = 0;
    init_delay = dly; stall_at = st_at; stall_left = st_len; done_after = d_after;
    dev_busy = 0; done_in = (d_after == 0);
    for (int i = 0; i < 64; i++) src[i] = 8'(i * 29 + 3);
  endtask

  task automatic feed(input int n);
    int i = 0;
    @(negedge clk);
    s_valid = 1; s_data = src[0]; s_last = (n == 1);
    while (i < n && op_busy) begin
      if (s_ready) begin
        @(negedge clk);
        i++;
        if (i < n) begin s_data = src[i]; s_last = (i == n - 1); end
      end else @(negedge clk);
    end
    s_valid = 0; s_last = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (op_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_load(input int n, input bit poke_rdbk);
    @(negedge clk) start_load = 1;
    @(negedge clk) start_load = 0;
    fork
      feed(n);
      wait_idle();
      if (poke_rdbk) begin
        repeat (12) @(negedge clk);
        start_rdbk = 1; rd_len = 8'd3;
        @(negedge clk) start_rdbk = 0;
      end
    join
  endtask

  function automatic int cap_mismatch(input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap[i] != src[i]) bad++;
    return bad;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(prog_n && cs_n && wr_n && cclk, "R1 pins idle", {prog_n, cs_n, wr_n, cclk}, 15);
    chk(!cfg_d_oe && !s_ready && !m_valid && !op_busy && !abort_pulse, "R1 outputs low",
        {cfg_d_oe, s_ready, m_valid, op_busy, abort_pulse}, 0);
  endtask

  task automatic t_basic();
    prep(5, 0, 0, 3);
    busy_chk_en = 1;
    run_load(6, 0);
    chk(prog_cnt == PROG, "R2 program pulse length", prog_cnt, PROG);
    chk(cs_fell && init_up && t_cs_fall > t_init, "R3 select after ready", int'(t_cs_fall), int'(t_init));
    chk(cap_n == 6 && cap_mismatch(6) == 0, "R5 bytes in order", cap_n, 6);
    chk(rises_ld == 6, "R5 one edge per byte", rises_ld, 6);
    chk(oe_bad == 0, "R4 drive only under select and write", oe_bad, 0);
    chk(t_wr_rise > t_cs_rise, "R8 select released before write", int'(t_wr_rise), int'(t_cs_rise));
    chk(rises_post == 3, "R9 clocks until done", rises_post, 3);
    chk(stat_ok && !stat_timeout && abort_cnt == 0, "R9 success status", {stat_ok, stat_timeout}, 2);
  endtask

  task automatic t_stall();
    prep(2, 3, 3, 0);
    busy_chk_en = 1;
    run_load(7, 0);
    chk(cap_n == 7 && cap_mismatch(7) == 0, "R6 stall keeps data", cap_n, 7);
    chk(rises_ld == 10, "R6 extra edges during busy", rises_ld, 10);
    chk(rises_post == 0, "R9 no pulse when done already high", rises_post, 0);
    chk(stat_ok, "R6 stall load ok", stat_ok, 1);
  endtask

  task automatic t_nocheck();
    prep(2, 2, 3, 1);
    busy_chk_en = 0;
    run_load(6, 0);
    chk(rises_ld == 6, "R6 no stall when checking off", rises_ld, 6);
    chk(stat_ok, "R6 unchecked load ok", stat_ok, 1);
  endtask

  task automatic t_init_to();
    prep(2, 0, 0, 0);
    init_stuck = 1;
    run_load(4, 0);
    init_stuck = 0; init_n = 1;
    chk(!cs_fell, "R3 select held while not ready", cs_fell, 0);
    chk(stat_timeout && !stat_ok && abort_cnt == 1, "R3 ready timeout aborts", abort_cnt, 1);
    chk(wait_cyc >= TO, "R3 timeout not early", wait_cyc, TO);
  endtask

  task automatic t_busy_to();
    prep(2, 2, 100000, 0);
    busy_chk_en = 1;
    run_load(5, 0);
    dev_busy = 0;
    chk(stat_timeout && abort_cnt == 1, "R7 busy stall timeout", abort_cnt, 1);
    chk(cs_n && wr_n && !cfg_d_oe, "R7 pins released", {cs_n, wr_n, cfg_d_oe}, 6);
  endtask

  task automatic t_done_to();
    prep(2, 0, 0, 100000);
    busy_chk_en = 1;
    run_load(3, 0);
    chk(abort_cnt == 1, "R10 single abort cycle", abort_cnt, 1);
    chk(stat_timeout && !stat_ok, "R10 done timeout status", {stat_ok, stat_timeout}, 1);
    chk(rises_post > 10, "R10 kept clocking before timeout", rises_post, 11);
  endtask

  task automatic t_rdbk(input int n);
    int bad = 0;
    prep(2, 0, 0, 100000);
    rd_len = 8'(n);
    @(negedge clk) start_rdbk = 1;
    @(negedge clk) start_rdbk = 0;
    wait_idle();
    for (int i = 0; i < n; i++) if (mv[i] != pat(i)) bad++;
    chk(mv_n == n && bad == 0, "R11 readback bytes in order", mv_n, n);
    chk(rises_rb == n && rises_ld == 0, "R11 one pulse per byte with write high", rises_rb, n);
    chk(oe_bad == 0 && prog_cnt == 0, "R11 bus undriven and no program", oe_bad, 0);
    chk(rises_post == 1, "R12 one trailing pulse", rises_post, 1);
    chk(stat_ok && !stat_timeout, "R12 readback ok", stat_ok, 1);
  endtask

  task automatic t_ignore();
    prep(2, 0, 0, 2);
    busy_chk_en = 1;
    run_load(8, 1);
    chk(mv_n == 0 && rises_rb == 0, "R13 readback request ignored", mv_n, 0);
    chk(cap_n == 8 && cap_mismatch(8) == 0 && stat_ok, "R13 load unaffected", cap_n, 8);
  endtask

  initial begin
    prep(2, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_stall();
    t_nocheck();
    t_init_to();
    t_busy_to();
    t_done_to();
    t_rdbk(5);
    t_rdbk(0);
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule